// File: doc/BRIEF.md
# Cascaded Two-Stage Clock Channel Divider

This block divides a fast input clock down to an output clock by running two programmable counters in series. Each counter has a 4-bit high-phase field and a 4-bit low-phase field and divides by the sum of the two fields plus two, so each counter covers ratios 2 through 32. Each counter also has its own bypass bit. The channel ratio is 1, the first counter's ratio, or the product of both ratios, up to 1024. Any ratio that is not such a product cannot be produced.

Both counters run on the input clock. The second counter advances only on the terminal-count pulse of the first, so the whole block stays in one clock domain. By default a duty-cycle corrector shapes the output to half the period. On odd ratios it adds a half-cycle extension taken from a falling-edge flop. With the corrector disabled, the high and low times come straight from the fields of the last active counter. A synchronous sync request clears both counters and the corrector, so the output phase is known once sync is released. Bypassing the first counter while the second is in use is not supported, and the block reports that setting.

Top module: `cdiv_top`

## Requirements
- R1: One counter divides by hi + lo + 2 input cycles; with correction off its high time is hi + 1 cycles.
- R2: With both bypass bits set, clk_o follows clk_i directly (divide by 1).
- R3: With only the second bypass bit set, the output period equals the first counter's ratio.
- R4: With neither bypass bit set, the period is the product of the two counter ratios. The second counter advances only on the first counter's terminal count. With correction off, the high time is (hi2 + 1) × ratio1 input cycles.
- R5: First bypass set with second bypass clear raises cfg_err_o and holds clk_o low. cfg_err_o is low for every other setting.
- R6: With dcc_off_i low and period P ≥ 2, clk_o is high for exactly P of every 2P input half-cycles, starting at the period's first rising edge. For odd P this includes a half-cycle extension.
- R7: With dcc_off_i high, the high/low split follows the fields of the last active counter (see R1, R4).
- R8: While sync_i is sampled high, the divided output is low. It rises on the first clk_i rising edge at which sync_i is sampled low again.
- R9: While rst_ni is low, clk_o is low in every setting except full bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Synchronous phase-restart request |
| s1_hi_i | input | 4 | First counter high cycles minus one |
| s1_lo_i | input | 4 | First counter low cycles minus one |
| s1_byp_i | input | 1 | Bypass the first counter |
| s2_hi_i | input | 4 | Second counter high cycles minus one |
| s2_lo_i | input | 4 | Second counter low cycles minus one |
| s2_byp_i | input | 1 | Bypass the second counter |
| dcc_off_i | input | 1 | Disable duty-cycle correction |
| clk_o | output | 1 | Divided output clock |
| cfg_err_o | output | 1 | Unsupported bypass combination |

## Verification
The bench samples clk_o in every half-cycle over two periods and compares each sample against a model built from the period and high-time formulas. This exposes a wrong ratio, a wrong split, or an off-by-one in counter wrap. The bench targets several corner cases:
- Odd products with correction on: a corrector without the falling-edge extension would be high for one half-cycle too few.
- The 1024 extreme: a second counter stepping every cycle, or a truncated product, would give a far shorter period.
- Minimum ratio 2 and ratio 32.
- The illegal bypass pair: an unflagged design would emit a clock there.
- Full bypass: this would show a stuck output if the input clock were not routed through.

// File: rtl/cdiv_pkg.sv
`timescale 1ns/1ps
package cdiv_pkg;
  localparam int FIELD_W = 4;

  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_ONE  = 2'd1,
    MODE_CASC = 2'd2,
    MODE_BAD  = 2'd3
  } div_mode_e;

  function automatic div_mode_e decode_mode(input logic byp1, input logic byp2);
    if (byp1 && byp2)      return MODE_PASS;
    else if (!byp1 && byp2) return MODE_ONE;
    else if (!byp1)        return MODE_CASC;
    else                   return MODE_BAD;
  endfunction
endpackage

// File: rtl/cdiv_stage.sv
`timescale 1ns/1ps
module cdiv_stage #(
  parameter int CW = 4,
  localparam int RW = CW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_i,
  input  logic          en_i,
  input  logic [CW-1:0] hi_i,
  input  logic [CW-1:0] lo_i,
  output logic [RW-1:0] cnt_o,
  output logic          tc_o,
  output logic          hi_ph_o
);
  logic [RW-1:0] cnt_q;
  logic [RW-1:0] last;

  // last count value = hi + lo + 1 (ratio - 1)
  assign last    = RW'(hi_i) + RW'(lo_i) + RW'(1);
  assign tc_o    = en_i && (cnt_q >= last);
  assign hi_ph_o = cnt_q <= RW'(hi_i);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (sync_i)  cnt_q <= '0;
    else if (en_i)    cnt_q <= tc_o ? '0 : cnt_q + RW'(1);
  end
endmodule

// File: rtl/cdiv_dcc.sv
`timescale 1ns/1ps
module cdiv_dcc #(
  parameter int PW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_i,
  input  logic          wrap_i,
  input  logic [PW-1:0] period_i,
  output logic          first_half_o,
  output logic          odd_o
);
  logic [PW-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pos_q <= '0;
    else if (sync_i)  pos_q <= '0;
    else if (wrap_i)  pos_q <= '0;
    else              pos_q <= pos_q + PW'(1);
  end

  assign first_half_o = pos_q < (period_i >> 1);
  assign odd_o        = period_i[0];
endmodule

// File: rtl/cdiv_top.sv
`timescale 1ns/1ps
module cdiv_top
  import cdiv_pkg::*;
#(
  parameter int CW = FIELD_W,
  localparam int RW = CW + 2,
  localparam int PW = 2 * RW,
  localparam int NSTG = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_i,
  input  logic [CW-1:0] s1_hi_i,
  input  logic [CW-1:0] s1_lo_i,
  input  logic          s1_byp_i,
  input  logic [CW-1:0] s2_hi_i,
  input  logic [CW-1:0] s2_lo_i,
  input  logic          s2_byp_i,
  input  logic          dcc_off_i,
  output logic          clk_o,
  output logic          cfg_err_o
);
  div_mode_e     mode;
  logic [CW-1:0] hi_f   [NSTG];
  logic [CW-1:0] lo_f   [NSTG];
  logic [RW-1:0] ratio  [NSTG];
  logic [RW-1:0] stg_cnt[NSTG];
  logic [NSTG-1:0] stg_tc;
  logic [NSTG-1:0] stg_hi;
  logic [PW-1:0] period;
  logic          wrap;
  logic          dcc_hi;
  logic          dcc_odd;
  logic          byp_all;
  logic          out_d, out_q, neg_q;

  assign mode      = decode_mode(s1_byp_i, s2_byp_i);
  assign byp_all   = (mode == MODE_PASS);
  assign cfg_err_o = (mode == MODE_BAD);

  assign hi_f[0] = s1_hi_i;
  assign lo_f[0] = s1_lo_i;
  assign hi_f[1] = s2_hi_i;
  assign lo_f[1] = s2_lo_i;

  for (genvar g = 0; g < NSTG; g++) begin : g_stg
    logic en;
    if (g == 0) begin : g_head
      assign en = 1'b1;
    end else begin : g_tail
      assign en = stg_tc[g-1];
    end
    assign ratio[g] = RW'(hi_f[g]) + RW'(lo_f[g]) + RW'(2);
    cdiv_stage #(.CW(CW)) i_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sync_i (sync_i),
      .en_i   (en),
      .hi_i   (hi_f[g]),
      .lo_i   (lo_f[g]),
      .cnt_o  (stg_cnt[g]),
      .tc_o   (stg_tc[g]),
      .hi_ph_o(stg_hi[g])
    );
  end

  assign period = (mode == MODE_CASC) ? PW'(ratio[0]) * PW'(ratio[1]) : PW'(ratio[0]);
  assign wrap   = (mode == MODE_CASC) ? stg_tc[1] : stg_tc[0];

  cdiv_dcc #(.PW(PW)) i_dcc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sync_i      (sync_i),
    .wrap_i      (wrap),
    .period_i    (period),
    .first_half_o(dcc_hi),
    .odd_o       (dcc_odd)
  );

  always_comb begin
    unique case (mode)
      MODE_ONE:  out_d = dcc_off_i ? stg_hi[0] : dcc_hi;
      MODE_CASC: out_d = dcc_off_i ? stg_hi[1] : dcc_hi;
      default:   out_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     out_q <= 1'b0;
    else if (sync_i) out_q <= 1'b0;
    else             out_q <= out_d;
  end

  // half-cycle stretch for odd periods
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= 1'b0;
    else         neg_q <= out_q;
  end

  assign clk_o = byp_all ? clk_i : (out_q | (neg_q & dcc_odd & ~dcc_off_i));
endmodule

// File: rtl/cdiv_chk.sv
`timescale 1ns/1ps
module cdiv_chk #(
  parameter int RW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sync_i,
  input logic          cfg_err_o,
  input logic          byp_all,
  input logic          out_q,
  input logic          tc1,
  input logic [RW-1:0] cnt1,
  input logic [RW-1:0] cnt2
);
  // R5
  bad_mode_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o && $past(cfg_err_o) |-> !out_q);

  // R8
  sync_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> !out_q);

  // R8
  sync_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sync_i) && !sync_i && !cfg_err_o && !byp_all |=> out_q);

  // R4
  stg2_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt2) |-> $past(tc1) || $past(sync_i));

  // R1
  stg1_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_i |=> (32'(cnt1) == 32'($past(cnt1)) + 1) || (cnt1 == '0));
endmodule

bind cdiv_top cdiv_chk #(.RW(RW)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sync_i   (sync_i),
  .cfg_err_o(cfg_err_o),
  .byp_all  (byp_all),
  .out_q    (out_q),
  .tc1      (stg_tc[0]),
  .cnt1     (stg_cnt[0]),
  .cnt2     (stg_cnt[1])
);

// File: tb/test_cdiv_top.sv
`timescale 1ns/1ps
module test_cdiv_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sync_i = 1'b0;
  logic [3:0] s1_hi_i = '0, s1_lo_i = '0, s2_hi_i = '0, s2_lo_i = '0;
  logic       s1_byp_i = 1'b0, s2_byp_i = 1'b1, dcc_off_i = 1'b0;
  logic       clk_o, cfg_err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk_i = ~clk_i;

  cdiv_top i_cdiv_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_i),
    .s1_hi_i(s1_hi_i), .s1_lo_i(s1_lo_i), .s1_byp_i(s1_byp_i),
    .s2_hi_i(s2_hi_i), .s2_lo_i(s2_lo_i), .s2_byp_i(s2_byp_i),
    .dcc_off_i(dcc_off_i), .clk_o(clk_o), .cfg_err_o(cfg_err_o)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic bit exp_bit(int k, int mode, int per, int hcyc, bit doff);
    int m;
    if (mode == 0) return (k % 2) == 0;
    if (mode == 3) return 1'b0;
    m = k % (2 * per);
    return doff ? (m < 2 * hcyc) : (m < per);
  endfunction

  task automatic run_cfg(int h1, int l1, bit b1, int h2, int l2, bit b2, bit doff);
    int mode, r1, r2, per, hcyc, nsmp, bad_k, act_b, exp_b;
    string tag;
    mode = b1 ? (b2 ? 0 : 3) : (b2 ? 1 : 2);
    r1 = h1 + l1 + 2;
    r2 = h2 + l2 + 2;
    per  = (mode == 2) ? r1 * r2 : r1;
    hcyc = (mode == 2) ? (h2 + 1) * r1 : h1 + 1;
    case (mode)
      0: tag = "R2";
      1: tag = doff ? "R3 R1 R7" : "R3 R6";
      2: tag = doff ? "R4 R7" : "R4 R6";
      default: tag = "R5";
    endcase
    @(negedge clk_i);
    s1_hi_i = 4'(h1); s1_lo_i = 4'(l1); s1_byp_i = b1;
    s2_hi_i = 4'(h2); s2_lo_i = 4'(l2); s2_byp_i = b2;
    dcc_off_i = doff; sync_i = 1'b1;
    #5;
    n_chk++;
    if (cfg_err_o !== (mode == 3)) begin
      n_bad++;
      $display("FAIL R5 cfg_err_o act=%0b exp=%0b", cfg_err_o, (mode == 3));
    end
    @(negedge clk_i); #5;
    if (mode != 0) begin
      n_chk++;
      if (clk_o !== 1'b0) begin
        n_bad++;
        $display("FAIL R8 output during sync act=%0b exp=0", clk_o);
      end
    end
    @(negedge clk_i);
    sync_i = 1'b0;
    #15;
    nsmp = (mode == 0) ? 16 : (mode == 3) ? 64 : 4 * per;
    bad_k = -1; act_b = 0; exp_b = 0;
    for (int k = 0; k < nsmp; k++) begin
      if (k != 0) #10;
      if (bad_k < 0 && clk_o !== exp_bit(k, mode, per, hcyc, doff)) begin
        bad_k = k; act_b = int'(clk_o); exp_b = int'(exp_bit(k, mode, per, hcyc, doff));
      end
    end
    n_chk++;
    if (bad_k >= 0) begin
      n_bad++;
      $display("FAIL %s h1=%0d l1=%0d h2=%0d l2=%0d byp=%0b%0b doff=%0b half-cycle %0d act=%0d exp=%0d",
               tag, h1, l1, h2, l2, b1, b2, doff, bad_k, act_b, exp_b);
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1c5e_d00d));
    // R9 reset state
    #35;
    n_chk++;
    if (clk_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R9 clk_o in reset act=%0b exp=0", clk_o);
    end
    rst_ni = 1'b1;
    // directed corners
    run_cfg(0, 0, 0, 0, 0, 1, 1);      // ratio 2, fields
    run_cfg(0, 0, 0, 0, 0, 1, 0);      // ratio 2, dcc
    run_cfg(15, 15, 0, 0, 0, 1, 1);    // ratio 32
    run_cfg(0, 1, 0, 0, 0, 1, 0);      // ratio 3 odd dcc
    run_cfg(5, 0, 0, 0, 0, 1, 1);      // lopsided split
    run_cfg(0, 1, 0, 1, 2, 0, 0);      // 3*5 odd product
    run_cfg(1, 0, 0, 2, 0, 0, 1);      // 3*4 fields
    run_cfg(15, 15, 0, 15, 15, 0, 0);  // 1024
    run_cfg(3, 4, 1, 2, 2, 1, 0);      // pass through
    run_cfg(3, 4, 1, 2, 2, 0, 0);      // illegal
    run_cfg(2, 2, 0, 1, 1, 1, 1);      // legal again after illegal
    // random mix
    for (int i = 0; i < 30; i++) begin
      int h1, l1, h2, l2, sel;
      bit b1, b2, doff;
      h1 = int'($urandom_range(0, 15)); l1 = int'($urandom_range(0, 15));
      h2 = int'($urandom_range(0, 7));  l2 = int'($urandom_range(0, 7));
      sel = int'($urandom_range(0, 9));
      b1 = (sel == 0) || (sel == 1);
      b2 = (sel == 0) || (sel >= 5);
      doff = 1'($urandom_range(0, 1));
      run_cfg(h1, l1, b1, h2, l2, b2, doff);
    end
    finish_run();
  end
endmodule